// File: doc/BRIEF.md
# Platform Reset Pulse Generator

This block drives the active-low reset line that holds the rest of a platform in reset. The reset stays asserted while power is not yet trustworthy. Power counts as good only when both the core power-good input and the voltage-regulator power-good input are high. Once both have been high without a break for a programmable number of fast-clock cycles, the line is released. That interval is 1 ms in a real system and a short value in simulation.

Software can also demand a hard reset with a one-cycle request strobe. The request produces a reset pulse of the same minimum length. A request that arrives while such a pulse is running starts the length over.

Both power-good inputs and the slow real-time clock (RTC) are asynchronous to the fast clock. They pass through two-stage synchronisers before use. Rising edges of the RTC are then detected in the fast-clock domain. A drop of power-good after release only counts when it stays low across a minimum number of RTC rising edges, so short dips are ignored.

Top module: `plat_rst_gen`

## Requirements
- R1: While the block reset `rst_ni` is low, and afterwards until a release condition is met, `plat_rst_no` is low.
- R2: Each power-good input passes through a two-flop synchroniser. With no software pulse active, `plat_rst_no` goes high on the (MIN_CYC+2)-th rising clock edge after the later of `core_pg_i` and `vreg_pg_i` goes high, provided both stay high.
- R3: A low on either synchronised power-good input, of any length, while reset is held for power reasons clears the release timer. The full MIN_CYC interval then starts again once both are high.
- R4: After release, a dip of combined power-good that spans fewer than FILT_RTC (default 3) synchronised RTC rising edges leaves `plat_rst_no` high.
- R5: After release, combined power-good that stays low across FILT_RTC consecutive synchronised RTC rising edges drives `plat_rst_no` low. This applies whether `core_pg_i` or `vreg_pg_i` is the input that dropped.
- R6: A one-cycle `sw_rst_req_i` sampled high drives `plat_rst_no` low from that clock edge. With power good, it goes high again exactly MIN_CYC edges later, so the pulse is MIN_CYC cycles wide.
- R7: A request sampled while a software pulse is active restarts the width. The line goes high MIN_CYC edges after the last request.
- R8: Every low period of `plat_rst_no` lasts at least MIN_CYC clock cycles.
- R9: After a power drop, release follows the same MIN_CYC+2 edge timing as R2, counted from the power-good input's return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Block reset, active low, asynchronous |
| rtc_clk_i | input | 1 | Slow real-time clock, asynchronous |
| core_pg_i | input | 1 | Core power-good, asynchronous |
| vreg_pg_i | input | 1 | Regulator power-good, asynchronous |
| sw_rst_req_i | input | 1 | One-cycle software hard-reset request |
| plat_rst_no | output | 1 | Platform reset, active low, registered |

## Verification
A software pulse pulls the line low right after the clock edge that samples the request. The line rises MIN_CYC edges after the last request. Power release comes MIN_CYC+2 edges after a power-good input goes high, so the bench counts exact edges from a falling-edge drive and samples on falling edges. The drop filter depends on the RTC phase, so the bench only checks fixed bounds for it. The line must still be high 12 cycles into a dip and must be low by 32 cycles.

// File: rtl/plat_rst_pkg.sv
package plat_rst_pkg;
    localparam int MIN_CYC_DEF  = 200000;
    localparam int FILT_RTC_DEF = 3;
    localparam int SYNC_DEF     = 2;
    localparam int IDX_CORE     = 0;
    localparam int IDX_VREG     = 1;
    localparam int IDX_RTC      = 2;
    localparam int NUM_ASYNC    = 3;
endpackage

// File: rtl/plat_rst_sync.sv
module plat_rst_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/plat_rst_drop_filter.sv
module plat_rst_drop_filter #(
    parameter int FILT_RTC = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pg_ok_i,
    input  logic rtc_rise_i,
    output logic drop_o
);
    localparam int CNT_W = $clog2(FILT_RTC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_RTC - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FILT_RTC);

    typedef struct packed {
        logic [CNT_W-1:0] low_edges;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        drop_o = 1'b0;
        if (pg_ok_i) begin
            st_d.low_edges = '0;
        end else if (rtc_rise_i && st_q.low_edges != CNT_FULL) begin
            st_d.low_edges = st_q.low_edges + 1'b1;
            drop_o = (st_q.low_edges == CNT_LAST);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/plat_rst_pulse_timer.sv
module plat_rst_pulse_timer #(
    parameter int MIN_CYC = 200000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic active_nxt_o
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MIN_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i)                 st_d.remain = CNT_LOAD;
        else if (st_q.remain != '0)  st_d.remain = st_q.remain - 1'b1;
        active_nxt_o = (st_d.remain != '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/plat_rst_gen.sv
module plat_rst_gen #(
    parameter int MIN_CYC  = plat_rst_pkg::MIN_CYC_DEF,
    parameter int FILT_RTC = plat_rst_pkg::FILT_RTC_DEF,
    parameter int SYNC_STG = plat_rst_pkg::SYNC_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rtc_clk_i,
    input  logic core_pg_i,
    input  logic vreg_pg_i,
    input  logic sw_rst_req_i,
    output logic plat_rst_no
);
    import plat_rst_pkg::*;

    localparam int HOLD_W = (MIN_CYC > 2) ? $clog2(MIN_CYC) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(MIN_CYC - 1);

    typedef struct packed {
        logic              pwr_lost;
        logic [HOLD_W-1:0] hold;
        logic              rtc_prev;
        logic              rst_n;
    } gen_st_t;

    localparam gen_st_t GEN_RESET = '{pwr_lost: 1'b1, hold: '0, rtc_prev: 1'b0, rst_n: 1'b0};

    gen_st_t st_d, st_q;

    logic [NUM_ASYNC-1:0] async_raw, async_s;
    logic pg_ok_s, rtc_rise, drop, sw_active_nxt;

    assign async_raw[IDX_CORE] = core_pg_i;
    assign async_raw[IDX_VREG] = vreg_pg_i;
    assign async_raw[IDX_RTC]  = rtc_clk_i;

    plat_rst_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STG)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (async_raw),
        .sync_o  (async_s)
    );

    assign pg_ok_s  = async_s[IDX_CORE] & async_s[IDX_VREG];
    assign rtc_rise = async_s[IDX_RTC] & ~st_q.rtc_prev;

    plat_rst_drop_filter #(.FILT_RTC(FILT_RTC)) u_filter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pg_ok_i    (pg_ok_s),
        .rtc_rise_i (rtc_rise),
        .drop_o     (drop)
    );

    plat_rst_pulse_timer #(.MIN_CYC(MIN_CYC)) u_timer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (sw_rst_req_i),
        .active_nxt_o (sw_active_nxt)
    );

    always_comb begin
        st_d = st_q;
        st_d.rtc_prev = async_s[IDX_RTC];
        if (drop) begin
            st_d.pwr_lost = 1'b1;
            st_d.hold     = '0;
        end else if (st_q.pwr_lost) begin
            if (!pg_ok_s) begin
                st_d.hold = '0;
            end else if (st_q.hold == HOLD_LAST) begin
                st_d.pwr_lost = 1'b0;
                st_d.hold     = '0;
            end else begin
                st_d.hold = st_q.hold + 1'b1;
            end
        end
        st_d.rst_n = !(st_d.pwr_lost || sw_active_nxt);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= GEN_RESET;
        else         st_q <= st_d;
    end

    assign plat_rst_no = st_q.rst_n;
endmodule

// File: rtl/plat_rst_gen_chk.sv
module plat_rst_gen_chk #(
    parameter int MIN_CYC  = 200000,
    parameter int FILT_RTC = 3
) (
    input logic clk_i,
    input logic rst_ni,
    input logic sw_rst_req_i,
    input logic plat_rst_no,
    input logic pg_ok_s,
    input logic rtc_rise
);
    localparam int RUN_W  = $clog2(MIN_CYC + 1);
    localparam int EDGE_W = $clog2(FILT_RTC + 1);
    localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(MIN_CYC);
    localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(FILT_RTC);

    logic [RUN_W-1:0]  low_run_q, since_req_q;
    logic [EDGE_W-1:0] low_edges_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            low_run_q   <= '0;
            since_req_q <= RUN_MAX;
            low_edges_q <= '0;
        end else begin
            if (plat_rst_no)            low_run_q <= '0;
            else if (low_run_q != RUN_MAX) low_run_q <= low_run_q + 1'b1;
            if (sw_rst_req_i)           since_req_q <= '0;
            else if (since_req_q != RUN_MAX) since_req_q <= since_req_q + 1'b1;
            if (pg_ok_s)                low_edges_q <= '0;
            else if (rtc_rise && low_edges_q != EDGE_MAX) low_edges_q <= low_edges_q + 1'b1;
        end
    end

    // R7 and R6: line is low within MIN_CYC edges of the latest request
    assert_sw_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        since_req_q < RUN_MAX |-> !plat_rst_no);

    assert_min_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(plat_rst_no) |-> low_run_q == RUN_MAX);

    assert_long_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_edges_q == EDGE_MAX |-> !plat_rst_no);

    assert_stay_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        plat_rst_no && pg_ok_s && !sw_rst_req_i |=> plat_rst_no);
endmodule

bind plat_rst_gen plat_rst_gen_chk #(.MIN_CYC(MIN_CYC), .FILT_RTC(FILT_RTC)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_rst_req_i (sw_rst_req_i),
    .plat_rst_no  (plat_rst_no),
    .pg_ok_s      (pg_ok_s),
    .rtc_rise     (rtc_rise)
);

// File: tb/plat_rst_gen_test.sv
`timescale 1ns/1ps
module plat_rst_gen_test;
    localparam int MIN  = 40;
    localparam int FILT = 3;

    logic clk = 1'b0, rtc = 1'b0;
    logic rst_n = 1'b0, core = 1'b0, vreg = 1'b0, req = 1'b0;
    logic out;
    int checks = 0, fails = 0, rem = 0;
    bit done = 1'b0;
    int unsigned seed_v;

    always #2.5 clk = ~clk;
    always #20  rtc = ~rtc;

    plat_rst_gen #(.MIN_CYC(MIN), .FILT_RTC(FILT), .SYNC_STG(2)) uut (
        .clk_i(clk), .rst_ni(rst_n), .rtc_clk_i(rtc), .core_pg_i(core),
        .vreg_pg_i(vreg), .sw_rst_req_i(req), .plat_rst_no(out));

    function automatic int release_lat();
        return MIN + 2;
    endfunction

    function automatic int sw_width(int gap);
        return gap + MIN;
    endfunction

    function automatic int sw_next(int r, bit rq);
        if (rq) return MIN;
        return (r > 0) ? r - 1 : 0;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic expect_release(string tag);
        cyc(release_lat() - 1);
        check(out == 1'b0, tag, out, 0);
        cyc(1);
        check(out == 1'b1, tag, out, 1);
    endtask

    task automatic measure_low(int gap, output int n);
        req = 1'b1; cyc(1); req = 1'b0;
        n = 0;
        while (!out && n < 1000) begin
            n++;
            req = (gap != 0 && n == gap);
            cyc(1);
        end
        req = 1'b0;
    endtask

    task automatic rstep(bit rq, string tag);
        req = rq; cyc(1); req = 1'b0;
        rem = sw_next(rem, rq);
        check(out == (rem == 0), tag, out, int'(rem == 0));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
            $finish;
        end
    end

    initial begin
        int n, bad;
        seed_v = $urandom(32'd4242);
        cyc(3);
        check(out == 1'b0, "R1 during block reset", out, 0);
        rst_n = 1'b1;
        cyc(100);
        check(out == 1'b0, "R1 no power after reset", out, 0);
        core = 1'b1; cyc(30);
        check(out == 1'b0, "R2 core alone", out, 0);
        vreg = 1'b1;
        expect_release("R2 power-up latency");

        measure_low(0, n);
        check(n == sw_width(0), "R6 sw pulse width", n, sw_width(0));
        cyc(5);
        measure_low(15, n);
        check(n == sw_width(15), "R7 restarted pulse width", n, sw_width(15));
        cyc(5);

        core = 1'b0; cyc(10); core = 1'b1;
        bad = 0;
        for (int i = 0; i < 60; i++) begin cyc(1); if (!out) bad++; end
        check(bad == 0, "R4 short core dip ignored", bad, 0);

        core = 1'b0; cyc(12);
        check(out == 1'b1, "R4 dip below filter length", out, 1);
        cyc(20);
        check(out == 1'b0, "R5 long core drop", out, 0);
        cyc(20); core = 1'b1;
        expect_release("R9 release after core drop");

        vreg = 1'b0; cyc(32);
        check(out == 1'b0, "R5 long regulator drop", out, 0);
        cyc(10);
        vreg = 1'b1; cyc(20); vreg = 1'b0; cyc(2); vreg = 1'b1;
        expect_release("R3 timer restart after dip");
        cyc(5);

        rem = 0;
        for (int it = 0; it < 300; it++) begin
            int act = $urandom % 8;
            if (act < 3) begin
                rstep(1'b1, "R6 R7 random request");
            end else if (act == 3) begin
                int len = 1 + $urandom % 12;
                bit which = $urandom % 2;
                if (which) core = 1'b0; else vreg = 1'b0;
                for (int k = 0; k < len; k++) rstep(1'b0, "R4 random dip");
                core = 1'b1; vreg = 1'b1;
            end else begin
                int len = 1 + $urandom % 20;
                for (int k = 0; k < len; k++) rstep(1'b0, "R6 random idle");
            end
        end
        for (int k = 0; k < MIN + 20; k++) rstep(1'b0, "R8 drain");

        done = 1'b1;
        report();
        $finish;
    end
endmodule